// File: doc/BRIEF.md
# Load Dependence Replay Matrix

This block decides which scheduled instructions must be replayed when a load misses. A scheduler window wakes consumers speculatively, assuming each load hits. That puts consumers into the pipeline before the hit or miss is known. Each window entry keeps a small bit grid for each of its two source operands. The grid has one column per load issue slot and one row per pipeline stage between issue and load verification. A load that issues seeds its own grid with one bit in the top row of its slot's column. When a consumer is woken by a tag broadcast, the producer's grid travels with the tag and is ORed into the operand's grid. Every cycle all grids move down by one row.

When a load slot reports a miss, every entry with a bit in that slot's column in the bottom row is hit in the same cycle. This covers the load itself and its whole dependence chain, however deep. An entry that had already issued returns to the window as unissued and raises a kill pulse. An entry that was woken but not yet issued loses the readiness of the tainted operand and raises an unready pulse. Entries that do not depend on the missing load keep going unchanged. A bit that moves past the bottom row without a miss belongs to a load that hit, so it is dropped. An issued entry whose grids are all empty has nothing left to verify, and its slot is freed.

Top module: `replay_dep_matrix`

## Requirements
- R1: After a synchronous reset, valid_o, req_o, kill_o, unrdy_o and iss_ok_o are all zero.
- R2: An allocated entry becomes valid with the given source tags and ready bits and with empty grids. Its req_o bit is set exactly when it is valid, not issued and both sources are ready.
- R3: A wakeup port whose tag equals an unready source of a valid entry marks that source ready and ORs the port's grid into that source's grid.
- R4: A grid is packed with bit index row*SLOTS+slot, where row 0 is the top row and row DEPTH-1 is the bottom. Every cycle each grid moves down one row, and bits that leave the bottom row are discarded.
- R5: Issuing a load in slot k sets row 0, column k of the entry's own grid before the shift. The cycle after issue, iss_ok_o is 1 and iss_mat_o shows that bit at row 1, ORed with the source grids.
- R6: If miss_i[k] is high while an entry that is issued, or is being issued, has a bottom-row bit in column k in any of its grids, then the entry returns to unissued with its own grid cleared, and kill_o pulses for that entry in the next cycle.
- R7: If miss_i[k] is high while an unissued entry has a bottom-row bit in column k in a source grid, then that source becomes unready with an empty grid, unrdy_o pulses in the next cycle, and req_o drops.
- R8: An entry with no bottom-row bit in any missing column is not changed by the miss.
- R9: A load killed only through its own grid keeps its sources ready and requests issue again in the next cycle.
- R10: A wakeup port whose grid has a bottom-row bit in a column that misses in the same cycle wakes no one.
- R11: An issued entry whose three grids are all empty after the update is released, and its valid_o bit falls in the next cycle.
- R12: iss_ok_o[p] is 1 in the cycle after issue port p fires, unless that entry is hit by a miss in the issue cycle. In that case it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_v_i | input | 1 | Write a new entry |
| alloc_idx_i | input | IDX_W | Entry to write |
| alloc_tag_i | input | 2*TAG_W | Source tags, source 0 in the low half |
| alloc_rdy_i | input | 2 | Initial source ready bits |
| wk_v_i | input | WAKE_N | Wakeup port valid |
| wk_tag_i | input | WAKE_N*TAG_W | Broadcast producer tags |
| wk_mat_i | input | WAKE_N*MAT_W | Producer grids sent with each tag |
| miss_i | input | SLOTS | Per load slot miss, in the verification cycle |
| iss_v_i | input | ISS_N | Issue port fires |
| iss_idx_i | input | ISS_N*IDX_W | Entry issued on each port |
| iss_load_i | input | ISS_N | Issued instruction is a load |
| iss_slot_i | input | ISS_N*SLOT_W | Load slot of a load on each port |
| valid_o | output | ENTRIES | Entry is occupied |
| req_o | output | ENTRIES | Entry is ready to issue |
| kill_o | output | ENTRIES | Issued entry cancelled, to be replayed |
| unrdy_o | output | ENTRIES | Woken entry made unready again |
| iss_ok_o | output | ISS_N | Issue of the previous cycle stands |
| iss_mat_o | output | ISS_N*MAT_W | Grid of that issued entry, to send with its tag |

## Verification
The bench uses eight entries, four-bit tags, two load slots, three grid rows, and two wakeup and two issue ports. With these values a load's bit reaches the bottom row two cycles after issue. That is short enough for directed cases to cover, within a dozen cycles, a chain of kills, a woken-but-unissued consumer, a poisoned broadcast and a verified load being dropped. Both slots and both ports can also collide in the same cycle. The random phase sends each issue result back as the next cycle's broadcast. Chains therefore form across the full window, and miss pulses land on every row alignment.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
  localparam int NSRC = 2;

  typedef enum logic [1:0] {
    RSP_NONE    = 2'd0,
    RSP_KILL    = 2'd1,
    RSP_UNREADY = 2'd2
  } rsp_e;
endpackage

// File: rtl/rdm_wake_match.sv
module rdm_wake_match #(
  parameter int TAG_W  = 4,
  parameter int SLOTS  = 2,
  parameter int MAT_W  = 6,
  parameter int WAKE_N = 2
) (
  input  logic [TAG_W-1:0]              src_tag_i,
  input  logic                          src_rdy_i,
  input  logic [WAKE_N-1:0]             wk_v_i,
  input  logic [WAKE_N-1:0][TAG_W-1:0]  wk_tag_i,
  input  logic [WAKE_N-1:0][MAT_W-1:0]  wk_mat_i,
  input  logic [SLOTS-1:0]              miss_i,
  output logic                          match_o,
  output logic [MAT_W-1:0]              mat_o
);
  logic [WAKE_N-1:0] hit;

  // R10: a producer that is itself being cancelled must not wake anyone
  for (genvar w = 0; w < WAKE_N; w++) begin : g_port
    logic poisoned;
    assign poisoned = |(wk_mat_i[w][MAT_W-1 -: SLOTS] & miss_i);
    assign hit[w]   = wk_v_i[w] && (wk_tag_i[w] == src_tag_i) && !poisoned && !src_rdy_i;
  end

  always_comb begin
    mat_o = '0;
    for (int w = 0; w < WAKE_N; w++) begin
      if (hit[w]) mat_o = mat_o | wk_mat_i[w];
    end
  end

  assign match_o = |hit;
endmodule

// File: rtl/rdm_entry.sv
module rdm_entry
  import rdm_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int SLOTS  = 2,
  parameter int DEPTH  = 3,
  parameter int WAKE_N = 2,
  localparam int MAT_W = SLOTS * DEPTH
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          alloc_i,
  input  logic [NSRC-1:0][TAG_W-1:0]    alloc_tag_i,
  input  logic [NSRC-1:0]               alloc_rdy_i,
  input  logic [WAKE_N-1:0]             wk_v_i,
  input  logic [WAKE_N-1:0][TAG_W-1:0]  wk_tag_i,
  input  logic [WAKE_N-1:0][MAT_W-1:0]  wk_mat_i,
  input  logic [SLOTS-1:0]              miss_i,
  input  logic                          issue_i,
  input  logic [MAT_W-1:0]              seed_i,
  output logic                          valid_o,
  output logic                          req_o,
  output logic [MAT_W-1:0]              mat_nxt_o,
  output logic                          kill_now_o,
  output rsp_e                          rsp_o
);
  logic                          valid_q, valid_n;
  logic                          issued_q, issued_n;
  logic                          req_q, req_n;
  logic [NSRC-1:0]               rdy_q, rdy_n;
  logic [NSRC-1:0][TAG_W-1:0]    tag_q, tag_n;
  logic [NSRC-1:0][MAT_W-1:0]    smat_q, smat_n;
  logic [MAT_W-1:0]              omat_q, omat_n;
  rsp_e                          rsp_q, rsp_n;

  logic [NSRC-1:0]               wk_match;
  logic [NSRC-1:0][MAT_W-1:0]    wk_mat;
  logic [NSRC-1:0]               src_hit;
  logic                          own_hit;
  logic                          killed;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    rdm_wake_match #(
      .TAG_W (TAG_W),
      .SLOTS (SLOTS),
      .MAT_W (MAT_W),
      .WAKE_N(WAKE_N)
    ) u_match (
      .src_tag_i(tag_q[s]),
      .src_rdy_i(rdy_q[s]),
      .wk_v_i   (wk_v_i),
      .wk_tag_i (wk_tag_i),
      .wk_mat_i (wk_mat_i),
      .miss_i   (miss_i),
      .match_o  (wk_match[s]),
      .mat_o    (wk_mat[s])
    );
    // R6/R7: bottom-row test against the slots that miss this cycle
    assign src_hit[s] = valid_q && |(smat_q[s][MAT_W-1 -: SLOTS] & miss_i);
  end

  assign own_hit = valid_q && |(omat_q[MAT_W-1 -: SLOTS] & miss_i);
  assign killed  = (|src_hit) || own_hit;

  always_comb begin
    valid_n  = valid_q;
    issued_n = issued_q;
    rdy_n    = rdy_q;
    tag_n    = tag_q;
    smat_n   = smat_q;
    omat_n   = omat_q;
    rsp_n    = RSP_NONE;
    if (alloc_i) begin
      valid_n  = 1'b1;
      issued_n = 1'b0;
      rdy_n    = alloc_rdy_i;
      tag_n    = alloc_tag_i;
      smat_n   = '0;
      omat_n   = '0;
    end else if (valid_q) begin
      for (int s = 0; s < NSRC; s++) begin
        if (src_hit[s]) begin
          rdy_n[s]  = 1'b0;
          smat_n[s] = '0;
        end else begin
          rdy_n[s]  = rdy_q[s] | wk_match[s];
          smat_n[s] = (smat_q[s] | (wk_match[s] ? wk_mat[s] : '0)) << SLOTS;
        end
      end
      if (killed) begin
        issued_n = 1'b0;
        omat_n   = '0;
        rsp_n    = (issued_q || issue_i) ? RSP_KILL : RSP_UNREADY;
      end else begin
        issued_n = issued_q | issue_i;
        omat_n   = (omat_q | (issue_i ? seed_i : '0)) << SLOTS;
      end
      // R11: nothing left to verify, free the slot
      if (issued_n && (smat_n == '0) && (omat_n == '0)) begin
        valid_n  = 1'b0;
        issued_n = 1'b0;
      end
    end
    req_n = valid_n && !issued_n && (&rdy_n);
  end

  always_comb begin
    mat_nxt_o = omat_n;
    for (int s = 0; s < NSRC; s++) mat_nxt_o = mat_nxt_o | smat_n[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      issued_q <= 1'b0;
      req_q    <= 1'b0;
      rdy_q    <= '0;
      tag_q    <= '0;
      smat_q   <= '0;
      omat_q   <= '0;
      rsp_q    <= RSP_NONE;
    end else begin
      valid_q  <= valid_n;
      issued_q <= issued_n;
      req_q    <= req_n;
      rdy_q    <= rdy_n;
      tag_q    <= tag_n;
      smat_q   <= smat_n;
      omat_q   <= omat_n;
      rsp_q    <= rsp_n;
    end
  end

  assign valid_o    = valid_q;
  assign req_o      = req_q;
  assign kill_now_o = killed;
  assign rsp_o      = rsp_q;
endmodule

// File: rtl/rdm_issue_port.sv
module rdm_issue_port #(
  parameter int ENTRIES = 8,
  parameter int MAT_W   = 6,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           iss_v_i,
  input  logic [IDX_W-1:0]               iss_idx_i,
  input  logic [ENTRIES-1:0][MAT_W-1:0]  ent_mat_i,
  input  logic [ENTRIES-1:0]             ent_kill_i,
  output logic                           ok_o,
  output logic [MAT_W-1:0]               mat_o
);
  // R12: an issue cancelled by a same-cycle miss is not acknowledged
  always_ff @(posedge clk) begin
    if (rst) begin
      ok_o  <= 1'b0;
      mat_o <= '0;
    end else begin
      ok_o  <= iss_v_i && !ent_kill_i[iss_idx_i];
      mat_o <= iss_v_i ? ent_mat_i[iss_idx_i] : '0;
    end
  end
endmodule

// File: rtl/replay_dep_matrix.sv
module replay_dep_matrix
  import rdm_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 4,
  parameter int SLOTS   = 2,
  parameter int DEPTH   = 3,
  parameter int WAKE_N  = 2,
  parameter int ISS_N   = 2,
  localparam int MAT_W  = SLOTS * DEPTH,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          alloc_v_i,
  input  logic [IDX_W-1:0]              alloc_idx_i,
  input  logic [1:0][TAG_W-1:0]         alloc_tag_i,
  input  logic [1:0]                    alloc_rdy_i,
  input  logic [WAKE_N-1:0]             wk_v_i,
  input  logic [WAKE_N-1:0][TAG_W-1:0]  wk_tag_i,
  input  logic [WAKE_N-1:0][MAT_W-1:0]  wk_mat_i,
  input  logic [SLOTS-1:0]              miss_i,
  input  logic [ISS_N-1:0]              iss_v_i,
  input  logic [ISS_N-1:0][IDX_W-1:0]   iss_idx_i,
  input  logic [ISS_N-1:0]              iss_load_i,
  input  logic [ISS_N-1:0][SLOT_W-1:0]  iss_slot_i,
  output logic [ENTRIES-1:0]            valid_o,
  output logic [ENTRIES-1:0]            req_o,
  output logic [ENTRIES-1:0]            kill_o,
  output logic [ENTRIES-1:0]            unrdy_o,
  output logic [ISS_N-1:0]              iss_ok_o,
  output logic [ISS_N-1:0][MAT_W-1:0]   iss_mat_o
);
  initial begin
    if (DEPTH < 2) $error("DEPTH must be at least 2");
  end

  logic [ENTRIES-1:0]            ent_issue;
  logic [ENTRIES-1:0][MAT_W-1:0] ent_seed;
  logic [ENTRIES-1:0][MAT_W-1:0] ent_mat;
  logic [ENTRIES-1:0]            ent_kill;
  rsp_e                          ent_rsp [ENTRIES];

  // R5: a load places one bit in the top row of its slot's column
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      ent_issue[e] = 1'b0;
      ent_seed[e]  = '0;
      for (int p = 0; p < ISS_N; p++) begin
        if (iss_v_i[p] && (iss_idx_i[p] == IDX_W'(e))) begin
          ent_issue[e] = 1'b1;
          if (iss_load_i[p]) ent_seed[e] = ent_seed[e] | (MAT_W'(1) << iss_slot_i[p]);
        end
      end
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    rdm_entry #(
      .TAG_W (TAG_W),
      .SLOTS (SLOTS),
      .DEPTH (DEPTH),
      .WAKE_N(WAKE_N)
    ) u_entry (
      .clk        (clk),
      .rst        (rst),
      .alloc_i    (alloc_v_i && (alloc_idx_i == IDX_W'(e))),
      .alloc_tag_i(alloc_tag_i),
      .alloc_rdy_i(alloc_rdy_i),
      .wk_v_i     (wk_v_i),
      .wk_tag_i   (wk_tag_i),
      .wk_mat_i   (wk_mat_i),
      .miss_i     (miss_i),
      .issue_i    (ent_issue[e]),
      .seed_i     (ent_seed[e]),
      .valid_o    (valid_o[e]),
      .req_o      (req_o[e]),
      .mat_nxt_o  (ent_mat[e]),
      .kill_now_o (ent_kill[e]),
      .rsp_o      (ent_rsp[e])
    );
    assign kill_o[e]  = (ent_rsp[e] == RSP_KILL);
    assign unrdy_o[e] = (ent_rsp[e] == RSP_UNREADY);
  end

  for (genvar p = 0; p < ISS_N; p++) begin : g_iss
    rdm_issue_port #(
      .ENTRIES(ENTRIES),
      .MAT_W  (MAT_W)
    ) u_port (
      .clk       (clk),
      .rst       (rst),
      .iss_v_i   (iss_v_i[p]),
      .iss_idx_i (iss_idx_i[p]),
      .ent_mat_i (ent_mat),
      .ent_kill_i(ent_kill),
      .ok_o      (iss_ok_o[p]),
      .mat_o     (iss_mat_o[p])
    );
  end
endmodule

// File: rtl/rdm_checker.sv
module rdm_checker #(
  parameter int ENTRIES = 8,
  parameter int SLOTS   = 2,
  parameter int ISS_N   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [SLOTS-1:0]   miss_i,
  input logic [ISS_N-1:0]   iss_v_i,
  input logic [ENTRIES-1:0] valid_o,
  input logic [ENTRIES-1:0] req_o,
  input logic [ENTRIES-1:0] kill_o,
  input logic [ENTRIES-1:0] unrdy_o,
  input logic [ISS_N-1:0]   iss_ok_o
);
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (valid_o == '0 && kill_o == '0 && unrdy_o == '0 && iss_ok_o == '0));

  a_r2_req_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (req_o & ~valid_o) == '0);

  a_r6_kill_unready_disjoint: assert property (@(posedge clk) disable iff (rst)
    (kill_o & unrdy_o) == '0);

  a_r7_unready_drops_req: assert property (@(posedge clk) disable iff (rst)
    (unrdy_o & req_o) == '0);

  a_r8_quiet_without_miss: assert property (@(posedge clk) disable iff (rst)
    !$past(|miss_i) |-> ((kill_o | unrdy_o) == '0));

  for (genvar p = 0; p < ISS_N; p++) begin : g_ack
    a_r12_ok_needs_issue: assert property (@(posedge clk) disable iff (rst)
      iss_ok_o[p] |-> $past(iss_v_i[p]));
  end
endmodule

bind replay_dep_matrix rdm_checker #(
  .ENTRIES(ENTRIES),
  .SLOTS  (SLOTS),
  .ISS_N  (ISS_N)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .miss_i  (miss_i),
  .iss_v_i (iss_v_i),
  .valid_o (valid_o),
  .req_o   (req_o),
  .kill_o  (kill_o),
  .unrdy_o (unrdy_o),
  .iss_ok_o(iss_ok_o)
);

// File: tb/replay_dep_matrix_bench.sv
module replay_dep_matrix_bench;
  localparam int CLK_PERIOD = 10;
  localparam int E  = 8;
  localparam int TW = 4;
  localparam int S  = 2;
  localparam int D  = 3;
  localparam int WN = 2;
  localparam int IN = 2;
  localparam int MW = S * D;
  localparam int IW = 3;
  localparam int SW = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic al_v;
  logic [IW-1:0] al_idx;
  logic [1:0][TW-1:0] al_tag;
  logic [1:0] al_rdy;
  logic [WN-1:0] wk_v;
  logic [WN-1:0][TW-1:0] wk_tag;
  logic [WN-1:0][MW-1:0] wk_mat;
  logic [S-1:0] miss;
  logic [IN-1:0] is_v;
  logic [IN-1:0][IW-1:0] is_idx;
  logic [IN-1:0] is_ld;
  logic [IN-1:0][SW-1:0] is_slot;
  logic [E-1:0] valid_o, req_o, kill_o, unrdy_o;
  logic [IN-1:0] iss_ok_o;
  logic [IN-1:0][MW-1:0] iss_mat_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  replay_dep_matrix #(.ENTRIES(E), .TAG_W(TW), .SLOTS(S), .DEPTH(D), .WAKE_N(WN), .ISS_N(IN)) u_replay_dep_matrix (
    .clk(clk), .rst(rst), .alloc_v_i(al_v), .alloc_idx_i(al_idx), .alloc_tag_i(al_tag),
    .alloc_rdy_i(al_rdy), .wk_v_i(wk_v), .wk_tag_i(wk_tag), .wk_mat_i(wk_mat), .miss_i(miss),
    .iss_v_i(is_v), .iss_idx_i(is_idx), .iss_load_i(is_ld), .iss_slot_i(is_slot),
    .valid_o(valid_o), .req_o(req_o), .kill_o(kill_o), .unrdy_o(unrdy_o),
    .iss_ok_o(iss_ok_o), .iss_mat_o(iss_mat_o));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state, built from the requirements
  logic [E-1:0] mv, mi;
  logic [1:0] mr [E];
  logic [1:0][TW-1:0] mt [E];
  logic [1:0][MW-1:0] ms [E];
  logic [MW-1:0] mo [E];
  logic [E-1:0] e_valid, e_req, e_kill, e_unrdy;
  logic [IN-1:0] e_ok;
  logic [IN-1:0][MW-1:0] e_mat;
  logic [IN-1:0][IW-1:0] prev_idx;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [S-1:0] bottom(input logic [MW-1:0] m);
    return m[MW-1 -: S];
  endfunction

  task automatic clear_drv();
    al_v = 0; al_idx = '0; al_tag = '0; al_rdy = '0;
    wk_v = '0; wk_tag = '0; wk_mat = '0; miss = '0;
    is_v = '0; is_idx = '0; is_ld = '0; is_slot = '0;
  endtask

  task automatic model_reset();
    mv = '0; mi = '0;
    for (int e = 0; e < E; e++) begin mr[e] = '0; mt[e] = '0; ms[e] = '0; mo[e] = '0; end
    e_valid = '0; e_req = '0; e_kill = '0; e_unrdy = '0; e_ok = '0; e_mat = '0;
  endtask

  task automatic model_step();
    logic [E-1:0] kil, ih;
    logic [MW-1:0] sd [E];
    logic [MW-1:0] nx [E];
    logic [1:0] sh;
    logic oh, m;
    logic [MW-1:0] acc;
    if (rst) begin model_reset(); return; end
    for (int e = 0; e < E; e++) begin
      ih[e] = 0; sd[e] = '0;
      for (int p = 0; p < IN; p++)
        if (is_v[p] && is_idx[p] == IW'(e)) begin
          ih[e] = 1;
          if (is_ld[p]) sd[e] = sd[e] | (MW'(1) << is_slot[p]);
        end
      kil[e] = mv[e] && (|(bottom(ms[e][0]) & miss) || |(bottom(ms[e][1]) & miss) || |(bottom(mo[e]) & miss));
    end
    e_kill = '0; e_unrdy = '0;
    for (int e = 0; e < E; e++) begin
      if (al_v && al_idx == IW'(e)) begin
        mv[e] = 1; mi[e] = 0; mr[e] = al_rdy; mt[e] = al_tag; ms[e] = '0; mo[e] = '0;
      end else if (mv[e]) begin
        for (int s = 0; s < 2; s++) begin
          sh[s] = |(bottom(ms[e][s]) & miss);
          if (sh[s]) begin mr[e][s] = 0; ms[e][s] = '0; end
          else begin
            m = 0; acc = '0;
            for (int w = 0; w < WN; w++)
              if (wk_v[w] && wk_tag[w] == mt[e][s] && !(|(bottom(wk_mat[w]) & miss)) && !mr[e][s]) begin
                m = 1; acc = acc | wk_mat[w];
              end
            mr[e][s] = mr[e][s] | m;
            ms[e][s] = (ms[e][s] | acc) << S;
          end
        end
        oh = |(bottom(mo[e]) & miss);
        if (sh != 2'b00 || oh) begin
          if (mi[e] || ih[e]) e_kill[e] = 1; else e_unrdy[e] = 1;
          mi[e] = 0; mo[e] = '0;
        end else begin
          mi[e] = mi[e] | ih[e];
          mo[e] = (mo[e] | sd[e]) << S;
        end
        if (mi[e] && ms[e][0] == '0 && ms[e][1] == '0 && mo[e] == '0) begin mv[e] = 0; mi[e] = 0; end
      end
      nx[e] = mo[e] | ms[e][0] | ms[e][1];
      e_req[e] = mv[e] && !mi[e] && (&mr[e]);
    end
    e_valid = mv;
    for (int p = 0; p < IN; p++) begin
      e_ok[p]  = is_v[p] && !kil[is_idx[p]];
      e_mat[p] = is_v[p] ? nx[is_idx[p]] : '0;
    end
    prev_idx = is_idx;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R11 valid_o", 64'(valid_o), 64'(e_valid));
    chk("R2 req_o", 64'(req_o), 64'(e_req));
    chk("R6 kill_o", 64'(kill_o), 64'(e_kill));
    chk("R7 unrdy_o", 64'(unrdy_o), 64'(e_unrdy));
    chk("R12 iss_ok_o", 64'(iss_ok_o), 64'(e_ok));
    chk("R4 iss_mat_o", 64'(iss_mat_o), 64'(e_mat));
    clear_drv();
  endtask

  task automatic alloc(input int idx, input logic [TW-1:0] t0, input logic r0, input logic [TW-1:0] t1, input logic r1);
    al_v = 1; al_idx = IW'(idx); al_tag[0] = t0; al_tag[1] = t1; al_rdy = {r1, r0};
    cyc();
  endtask

  initial begin
    clear_drv();
    model_reset();
    void'($urandom(32'd20250417));
    rst = 1;
    cyc(); cyc();
    rst = 0;
    chk("R1 valid after reset", 64'(valid_o), 64'd0);
    chk("R1 kill/unrdy after reset", 64'(kill_o | unrdy_o), 64'd0);
    chk("R1 iss_ok after reset", 64'(iss_ok_o), 64'd0);

    // directed sequence
    alloc(0, 4'd8, 1, 4'd9, 1);
    alloc(1, 4'd0, 0, 4'd9, 1);
    alloc(2, 4'd8, 1, 4'd9, 1);
    alloc(3, 4'd8, 1, 4'd9, 1);
    alloc(4, 4'd5, 0, 4'd9, 1);
    alloc(5, 4'd0, 0, 4'd9, 1);
    chk("R2 requests after alloc", 64'(req_o), 64'h0D);
    is_v = 2'b11; is_idx[0] = 3'd0; is_ld[0] = 1; is_slot[0] = 1'b1; is_idx[1] = 3'd2;
    cyc();
    chk("R5 load seed row1 slot1", 64'(iss_mat_o), 64'h008);
    chk("R12 both issues acked", 64'(iss_ok_o), 64'h3);
    chk("R11 non-load freed", 64'(valid_o), 64'h3B);
    wk_v[0] = 1; wk_tag[0] = 4'd0; wk_mat[0] = 6'b001000;
    cyc();
    chk("R3 wakeup of e1 and e5", 64'(req_o), 64'h2A);
    is_v[0] = 1; is_idx[0] = 3'd1; miss = 2'b10;
    wk_v[1] = 1; wk_tag[1] = 4'd5; wk_mat[1] = 6'b100000;
    cyc();
    chk("R6 load and issued consumer killed", 64'(kill_o), 64'h03);
    chk("R12 cancelled issue not acked", 64'(iss_ok_o), 64'h0);
    chk("R7 woken consumer unready", 64'(unrdy_o), 64'h20);
    chk("R9 R8 load re-requests, independent e3 kept", 64'(req_o), 64'h09);
    chk("R10 poisoned broadcast wakes nobody", 64'(req_o[4] | unrdy_o[4]), 64'd0);
    is_v[0] = 1; is_idx[0] = 3'd0; is_ld[0] = 1; is_slot[0] = 1'b0;
    cyc();
    chk("R5 load seed row1 slot0", 64'(iss_mat_o), 64'h004);
    cyc();
    chk("R4 bit still in bottom row", 64'(valid_o[0]), 64'd1);
    cyc();
    chk("R4 R11 verified load dropped and freed", 64'(valid_o[0]), 64'd0);

    // random phase, issue results fed back as broadcasts
    for (int n = 0; n < 3000; n++) begin
      if (n % 700 == 699) begin
        rst = 1; cyc(); cyc(); rst = 0;
        chk("R1 valid after reset", 64'(valid_o), 64'd0);
        continue;
      end
      for (int p = 0; p < WN; p++) begin
        wk_v[p] = e_ok[p]; wk_tag[p] = TW'(prev_idx[p]); wk_mat[p] = e_mat[p];
      end
      for (int s = 0; s < S; s++) miss[s] = ($urandom % 6 == 0);
      begin
        int a;
        a = $urandom % E;
        if (!mv[a] && ($urandom % 2 == 0)) begin
          al_v = 1; al_idx = IW'(a);
          for (int s = 0; s < 2; s++) begin
            int t;
            t = $urandom % 16;
            al_tag[s] = TW'(t);
            al_rdy[s] = (t >= E) || !mv[t];
          end
        end
      end
      for (int p = 0; p < IN; p++) begin
        int c;
        c = $urandom % E;
        if (e_req[c] && !(p == 1 && is_v[0] && is_idx[0] == IW'(c))) begin
          is_v[p] = 1; is_idx[p] = IW'(c);
          is_ld[p] = $urandom % 2; is_slot[p] = SW'($urandom % S);
        end
      end
      cyc();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule